// File: doc/BRIEF.md
# Programmable Delay Pre-Trigger Channel

This block is one channel of a trigger scheduler that places converter start pulses at programmed points after a trigger event. A trigger can come from a rising edge on a hardware line or from a software strobe. It resets a delay counter, which then counts up and halts once it reaches a programmable modulus. Each of the M pre-trigger lanes makes a one-clock pulse in one of three ways: directly from the trigger (bypass), from a compare between the counter and its own delay value (delayed), or from the previous lane's conversion-complete pulse (chained). Chaining lets a sequence of conversions step across successive sets of converter registers.

A separate compare against an interrupt-delay value raises a one-clock interrupt pulse at a scheduled point in the count. The modulus, interrupt-delay and lane delay values are double-buffered. Writes go to a holding copy, and that copy moves into the active copy when the next trigger starts a count. Readback of these addresses always returns the active copy. A channel trigger output is high whenever any lane pulses.

Top module: `pdt_channel`

## Requirements
- R1: The control register is at address 0. Lane enables are in bits [7:0], output selects in bits [15:8] (1 = delayed, 0 = bypass) and chain enables in bits [23:16]. Only the low M bits of each field are stored. All other bits read as 0, and writes to them have no effect.
- R2: Bit 0 of the mode register (address 1) picks the trigger source: 1 selects the software strobe, 0 selects rising edges of the hardware line. The source that is not selected has no effect. A hardware line held high gives exactly one trigger.
- R3: A lane that is enabled, in bypass, and not chained pulses in the cycle right after the edge that samples the trigger.
- R4: A lane that is enabled, delayed, and not chained, with active delay D, pulses in the cycle after the (D+1)th rising edge that follows the edge sampling the trigger. Lane k's delay is at address 4+k.
- R5: Every pre-trigger is a single-clock pulse. A lane whose enable bit is 0 never pulses, whatever its mode.
- R6: A chained lane k pulses one clock after a pulse on conversion-complete input k-1 (lane 0 follows input M-1). It ignores both the trigger and the counter compare.
- R7: When mode bit 1 is set, the interrupt output pulses once at the counter value held at address 3. The timing follows R4. When the bit is clear, the interrupt never pulses.
- R8: Writes to the modulus (address 2), interrupt delay (address 3) and lane delays take effect only at the next trigger. Reads of these addresses return the active values.
- R9: The counter halts after it reaches the active modulus. A delay equal to the modulus still fires. A delay above the modulus never fires.
- R10: The channel trigger output is high in exactly the cycles in which at least one pre-trigger output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_trig_i | input | 1 | Hardware trigger line, edge detected |
| sw_trig_i | input | 1 | Software trigger strobe |
| conv_done_i | input | M | Per-lane conversion-complete pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| pretrig_o | output | M | Per-lane pre-trigger pulses |
| ch_trig_o | output | 1 | Channel trigger |
| irq_o | output | 1 | Scheduled interrupt pulse |

## Verification
Bypass and chained pulses are due one edge after the stimulus is sampled. A delayed pulse or the interrupt is due D+1 edges after that, because the trigger is first registered, the counter then needs D increments, and the compare result is itself registered. The bench applies every stimulus on a falling edge. It then records the outputs at each following falling edge into a window indexed from the first edge. Each check compares the first index and the number of high cycles against those offsets, so a pulse that is early, late or repeated is caught.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int REG_W   = 32;
  localparam int FLD_W   = 8;
  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_MOD  = 2;
  localparam int ADR_IDLY = 3;
  localparam int ADR_DLY0 = 4;
  localparam int MODE_SW  = 0;
  localparam int MODE_IRQ = 1;

  // Compare of a running counter against a mark, widened to 32 bits
  function automatic logic at_mark(logic run, logic [31:0] cnt, logic [31:0] mark);
    return run && (cnt == mark);
  endfunction

  // Assemble the control readback from its three fields
  function automatic logic [REG_W-1:0] ctrl_pack(logic [FLD_W-1:0] en,
                                                 logic [FLD_W-1:0] sel,
                                                 logic [FLD_W-1:0] chain);
    return {8'h00, chain, sel, en};
  endfunction
endpackage

// File: rtl/pdt_trig_src.sv
module pdt_trig_src (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_trig_i,
  input  logic sw_trig_i,
  input  logic sw_sel_i,
  output logic hw_edge_o,
  output logic start_o
);
  logic hw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hw_q <= 1'b0;
    else        hw_q <= hw_trig_i;
  end

  assign hw_edge_o = hw_trig_i & ~hw_q;
  assign start_o   = sw_sel_i ? sw_trig_i : hw_edge_o;

  p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hw_edge_o |=> !hw_edge_o);
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] mod_buf_i,
  input  logic [CNT_W-1:0] idly_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic [CNT_W-1:0] idly_act_o,
  output logic             irq_o
);
  import pdt_pkg::*;

  logic irq_hit;
  logic at_end;

  assign irq_hit = at_mark(running_o, 32'(cnt_o), 32'(idly_act_o));
  assign at_end  = (cnt_o == mod_act_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o      <= '0;
      running_o  <= 1'b0;
      mod_act_o  <= '1;
      idly_act_o <= '0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= irq_en_i & irq_hit;
      if (start_i) begin
        cnt_o      <= '0;
        running_o  <= 1'b1;
        mod_act_o  <= mod_buf_i;
        idly_act_o <= idly_buf_i;
      end else if (running_o) begin
        if (at_end) running_o <= 1'b0;
        else        cnt_o     <= cnt_o + 1'b1;
      end
    end
  end

  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (cnt_o <= mod_act_o));
  p_stop_at_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && at_end && !start_i) |=> !running_o);
  p_idly_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(idly_act_o));
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |=> !irq_o);
endmodule

// File: rtl/pdt_lane.sv
module pdt_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             delayed_i,
  input  logic             chain_i,
  input  logic             start_i,
  input  logic             running_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dly_buf_i,
  input  logic             done_prev_i,
  output logic [CNT_W-1:0] dly_act_o,
  output logic             pulse_o
);
  import pdt_pkg::*;

  logic hit;
  logic fire;

  assign hit  = at_mark(running_i, 32'(cnt_i), 32'(dly_act_o));
  assign fire = chain_i ? done_prev_i : (delayed_i ? hit : start_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_act_o <= '0;
      pulse_o   <= 1'b0;
    end else begin
      pulse_o <= en_i & fire;
      if (start_i) dly_act_o <= dly_buf_i;
    end
  end

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !delayed_i && !chain_i && start_i) |=> pulse_o);
  p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && chain_i && done_prev_i) |=> pulse_o);
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pulse_o);
  p_dly_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(dly_act_o));
endmodule

// File: rtl/pdt_channel.sv
module pdt_channel #(
  parameter int M      = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_trig_i,
  input  logic              sw_trig_i,
  input  logic [M-1:0]      conv_done_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic [M-1:0]      pretrig_o,
  output logic              ch_trig_o,
  output logic              irq_o
);
  import pdt_pkg::*;

  localparam int SEL_LSB   = FLD_W;
  localparam int CHAIN_LSB = 2 * FLD_W;

  logic [M-1:0]     en_q, sel_q, chain_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] mod_buf, idly_buf;
  logic [CNT_W-1:0] dly_buf [M];
  logic [CNT_W-1:0] dly_act [M];
  logic [CNT_W-1:0] cnt, mod_act, idly_act;
  logic             running, start, hw_edge;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i;

  // Register file: control and mode are live, delays are holding copies
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      sel_q    <= '0;
      chain_q  <= '0;
      mode_q   <= '0;
      mod_buf  <= '1;
      idly_buf <= '0;
      for (int k = 0; k < M; k++) dly_buf[k] <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADR_CTRL)) begin
        en_q    <= wr_data_i[M-1:0];
        sel_q   <= wr_data_i[SEL_LSB +: M];
        chain_q <= wr_data_i[CHAIN_LSB +: M];
      end
      if (wr_addr_i == ADDR_W'(ADR_MODE)) mode_q   <= wr_data_i[1:0];
      if (wr_addr_i == ADDR_W'(ADR_MOD))  mod_buf  <= wr_data_i[CNT_W-1:0];
      if (wr_addr_i == ADDR_W'(ADR_IDLY)) idly_buf <= wr_data_i[CNT_W-1:0];
      for (int k = 0; k < M; k++)
        if (wr_addr_i == ADDR_W'(ADR_DLY0 + k)) dly_buf[k] <= wr_data_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADR_CTRL))
      rd_data_o = ctrl_pack(FLD_W'(en_q), FLD_W'(sel_q), FLD_W'(chain_q));
    if (rd_addr_i == ADDR_W'(ADR_MODE)) rd_data_o = 32'(mode_q);
    if (rd_addr_i == ADDR_W'(ADR_MOD))  rd_data_o = 32'(mod_act);
    if (rd_addr_i == ADDR_W'(ADR_IDLY)) rd_data_o = 32'(idly_act);
    for (int k = 0; k < M; k++)
      if (rd_addr_i == ADDR_W'(ADR_DLY0 + k)) rd_data_o = 32'(dly_act[k]);
  end

  pdt_trig_src u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_trig_i (hw_trig_i),
    .sw_trig_i (sw_trig_i),
    .sw_sel_i  (mode_q[MODE_SW]),
    .hw_edge_o (hw_edge),
    .start_o   (start)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .irq_en_i   (mode_q[MODE_IRQ]),
    .mod_buf_i  (mod_buf),
    .idly_buf_i (idly_buf),
    .cnt_o      (cnt),
    .running_o  (running),
    .mod_act_o  (mod_act),
    .idly_act_o (idly_act),
    .irq_o      (irq_o)
  );

  for (genvar k = 0; k < M; k++) begin : g_lane
    localparam int PREV = (k == 0) ? M - 1 : k - 1;
    pdt_lane #(.CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_q[k]),
      .delayed_i   (sel_q[k]),
      .chain_i     (chain_q[k]),
      .start_i     (start),
      .running_i   (running),
      .cnt_i       (cnt),
      .dly_buf_i   (dly_buf[k]),
      .done_prev_i (conv_done_i[PREV]),
      .dly_act_o   (dly_act[k]),
      .pulse_o     (pretrig_o[k])
    );
  end

  assign ch_trig_o = |pretrig_o;

  p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADDR_W'(ADR_CTRL)) |-> (rd_data_o[31:24] == 8'h00));
  p_chtrig_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_trig_o |-> (pretrig_o != '0));
endmodule

// File: tb/pdt_channel_tb.sv
`timescale 1ns/1ps
module pdt_channel_tb_top;
  localparam int M = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_trig_i = 1'b0, sw_trig_i = 1'b0, wr_en_i = 1'b0;
  logic [M-1:0]  conv_done_i = '0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic [31:0]   rd_data_o;
  logic [M-1:0]  pretrig_o;
  logic          ch_trig_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [M-1:0] ph [32];
  logic         ih [32];
  logic         chh [32];

  always #2 clk = ~clk;

  pdt_channel #(.M(M), .CNT_W(16), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_trig_i(hw_trig_i), .sw_trig_i(sw_trig_i),
    .conv_done_i(conv_done_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .pretrig_o(pretrig_o), .ch_trig_o(ch_trig_o), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    rd_addr_i = AW'(a);
    #0.5;
    d = rd_data_o;
  endtask

  task automatic fire_sw();
    @(negedge clk); sw_trig_i = 1'b1;
    @(negedge clk); sw_trig_i = 1'b0;
  endtask

  task automatic fire_hw();
    @(negedge clk); hw_trig_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_done(logic [M-1:0] v);
    @(negedge clk); conv_done_i = v;
    @(negedge clk); conv_done_i = '0;
  endtask

  // Index 0 is the cycle after the edge that sampled the stimulus
  task automatic capture(int n);
    for (int j = 0; j < n; j++) begin
      ph[j] = pretrig_o; ih[j] = irq_o; chh[j] = ch_trig_o;
      @(negedge clk);
    end
    for (int j = n; j < 32; j++) begin ph[j] = '0; ih[j] = 1'b0; chh[j] = 1'b0; end
  endtask

  task automatic lane_chk(string req, int lane, int first, int count);
    int f = -1; int c = 0;
    for (int j = 0; j < 32; j++) if (ph[j][lane]) begin c++; if (f < 0) f = j; end
    chk({req, " first"}, f, first);
    chk({req, " count"}, c, count);
  endtask

  task automatic irq_chk(string req, int first, int count);
    int f = -1; int c = 0;
    for (int j = 0; j < 32; j++) if (ih[j]) begin c++; if (f < 0) f = j; end
    chk({req, " first"}, f, first);
    chk({req, " count"}, c, count);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R5 reset pretrig", int'(pretrig_o), 0);
    chk("R7 reset irq", int'(irq_o), 0);
    rd(0, d); chk("R1 reset ctrl", int'(d), 0);
    rd(3, d); chk("R8 reset idly", int'(d), 0);
    rd(2, d); chk("R8 reset modulus", int'(d), 32'hFFFF);
  endtask

  task automatic t_ctrl_mask();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R1 ctrl mask", int'(d), 32'h000F_0F0F);
    wr(0, 32'h0);
  endtask

  task automatic t_bypass_sw();
    int c = 0;
    wr(1, 32'h1);
    wr(0, 32'h0000_0003);
    fire_sw(); capture(6);
    lane_chk("R3 lane0 bypass", 0, 0, 1);
    lane_chk("R3 lane1 bypass", 1, 0, 1);
    lane_chk("R5 lane2 disabled", 2, -1, 0);
    for (int j = 0; j < 32; j++) if (chh[j] != (ph[j] != '0)) c++;
    chk("R10 ch_trig tracks pretrig", c, 0);
  endtask

  task automatic t_hw_select();
    wr(1, 32'h0);
    fire_sw(); capture(4);
    lane_chk("R2 sw ignored when hw selected", 0, -1, 0);
    fire_hw(); capture(6);
    lane_chk("R2 hw held high one trigger", 0, 0, 1);
    hw_trig_i = 1'b0;
  endtask

  task automatic t_delayed();
    wr(0, 32'h0000_0405);
    wr(6, 32'd5);
    fire_hw(); capture(12);
    lane_chk("R4 lane2 delay 5", 2, 6, 1);
    lane_chk("R3 lane0 bypass with hw", 0, 0, 1);
    hw_trig_i = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3, 32'd3);
    wr(1, 32'h2);
    rd(3, d); chk("R8 idly read before trigger", int'(d), 0);
    fire_hw(); capture(12);
    irq_chk("R7 irq at idly 3", 4, 1);
    rd(3, d); chk("R8 idly read after trigger", int'(d), 3);
    hw_trig_i = 1'b0;
    wr(1, 32'h0);
    fire_hw(); capture(12);
    irq_chk("R7 irq disabled", -1, 0);
    hw_trig_i = 1'b0;
  endtask

  task automatic t_chain();
    wr(0, 32'h0002_0203);
    wr(5, 32'd0);
    wr(1, 32'h1);
    fire_sw(); capture(8);
    lane_chk("R3 chain head lane0", 0, 0, 1);
    lane_chk("R6 chained lane ignores counter", 1, -1, 0);
    pulse_done(4'b0001); capture(4);
    lane_chk("R6 chained lane1 follows done0", 1, 0, 1);
    lane_chk("R6 lane0 quiet on done", 0, -1, 0);
  endtask

  task automatic t_modulus();
    logic [31:0] d;
    wr(0, 32'h0000_0404);
    wr(2, 32'd4);
    wr(6, 32'd6);
    fire_sw(); capture(12);
    lane_chk("R9 delay above modulus", 2, -1, 0);
    rd(2, d); chk("R8 modulus active", int'(d), 4);
    wr(6, 32'd4);
    fire_sw(); capture(12);
    lane_chk("R9 delay equal modulus", 2, 5, 1);
  endtask

  task automatic t_disabled_delayed();
    int c = 0;
    wr(2, 32'd20);
    wr(0, 32'h0000_0F00);
    fire_sw(); capture(24);
    for (int j = 0; j < 32; j++) if (ph[j] != '0 || chh[j]) c++;
    chk("R5 disabled delayed lanes silent", c, 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_bypass_sw();
    t_hw_select();
    t_delayed();
    t_irq();
    t_chain();
    t_modulus();
    t_disabled_delayed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule